// File: doc/BRIEF.md
# Serial Controller Register and FIFO Front-End

This block is the register side of a serial I/O controller. It sits on a 32-bit big-endian bus that has byte enables. Every access completes in a single cycle with no wait states. Software sees six control and status words, a transmit FIFO write port and a receive FIFO read port. Toward the line side the block moves whole bytes over two valid/ready streams, one per direction. Bit framing, baud timing and modem flow control happen downstream and are not part of this block.

Each control word keeps only the bits its own write mask allows. Two status flags are sticky. The receive flag is set whenever the receive FIFO holds data. The transmit flag is set whenever the transmit FIFO is empty. Software clears a flag by writing zero to it, and the flag is set again at once if its condition still holds. A level interrupt is raised while any status flag meets its matching enable bit. Software can empty either FIFO through the FIFO control word, but only when the flush enable bit is part of the same written value.

Top module: `sio_regfront`

## Requirements
- R1: After reset the words read as follows: line control (byte offset 0x00) 0x40000000, baud control (0x14) 0x03FF0000, interrupt enable (0x08) 0, FIFO control (0x10) 0 and line status (0x04) 0. Both FIFOs are empty, so `tx_valid` is 0 and `rx_ready` is 1.
- R2: A write changes only the byte lanes whose enables are set. `bus_be[3]` selects bits 31:24 and `bus_be[0]` selects bits 7:0. After the merge, the word is ANDed with its own mask: line control 0xE17F0000, interrupt enable 0x000F0000, interrupt status 0x00070000, FIFO control 0x001F0000, baud control 0x03FF0000. Line status (mask 0) always reads zero.
- R3: A write to offset 0x20 with `bus_be[3]` set pushes `bus_wdata[31:24]` into the transmit FIFO. Writes to that offset without `bus_be[3]` push nothing. The FIFO holds 16 bytes, and a push while it is full is dropped. Bytes leave on `tx_data` in the order they were written, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R4: A receive byte is accepted when `rx_valid` and `rx_ready` are both high. `rx_ready` is low only while the receive FIFO holds 16 bytes, and a byte offered then is lost. A read of offset 0x30 with `bus_be[3]` set pops one byte and returns it in bits 31:24. A read of offset 0x30 without that lane pops nothing. An empty FIFO reads as zero, and offset 0x20 always reads as zero.
- R5: Interrupt status bit 16 (receive flag) is set on every clock edge at which the receive FIFO is non-empty. Bit 17 (transmit flag) is set on every edge at which the transmit FIFO is empty. A software write is applied first in the same cycle, so a flag written to zero stays clear only once its condition has gone.
- R6: `irq` is high exactly while interrupt status bits 18:16 AND interrupt enable bits 18:16 are non-zero. Bit 16 is receive, bit 17 is transmit and bit 18 is error.
- R7: A write to FIFO control whose resulting value has bit 16 set empties the receive FIFO if bit 17 is set and the transmit FIFO if bit 18 is set. Without bit 16, no FIFO is emptied.
- R8: `dma_err` is high while interrupt enable bit 19 (the unsupported DMA request) is set.
- R9: Writes to unmapped offsets, and to addresses whose low two bits are not zero, change nothing. Reads of such addresses return zero.
- R10: Read data appears on `bus_rdata` after the clock edge that accepts the read. Byte lanes whose enable was clear read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the 256-byte window |
| bus_be | input | 4 | Byte lane enables, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_data | output | 8 | Transmit byte toward the line |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Line side takes the transmit byte |
| rx_data | input | 8 | Received byte from the line |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive FIFO has room |
| irq | output | 1 | Level interrupt |
| dma_err | output | 1 | Unsupported DMA request is enabled |

## Verification
Register writes, FIFO pushes, pops and flushes take effect at the clock edge that accepts them. `irq`, `dma_err`, `tx_valid` and `rx_ready` therefore change right after that edge. The bench samples them one time unit after the edge, once each driver task returns. Read data is due one edge after the read request. The driver queues the expected word, and a monitor compares it at the following falling edge. Sticky flags appear one edge after the FIFO state that sets them, so status reads are issued at least one cycle after the last push or pop. Transmit bytes are compared against a queue of expected bytes at the falling edge before each handshake edge.

// File: rtl/sio_rf_pkg.sv
package sio_rf_pkg;

  // Byte offsets decoded from the bus address (software visible, fixed)
  localparam logic [7:0] OFS_LCTL  = 8'h00;
  localparam logic [7:0] OFS_LSTAT = 8'h04;
  localparam logic [7:0] OFS_IEN   = 8'h08;
  localparam logic [7:0] OFS_ISTAT = 8'h0C;
  localparam logic [7:0] OFS_FCTL  = 8'h10;
  localparam logic [7:0] OFS_BAUD  = 8'h14;
  localparam logic [7:0] OFS_TXF   = 8'h20;
  localparam logic [7:0] OFS_RXF   = 8'h30;

  // Per-word write masks
  localparam logic [31:0] MSK_LCTL  = 32'hE17F_0000;
  localparam logic [31:0] MSK_IEN   = 32'h000F_0000;
  localparam logic [31:0] MSK_ISTAT = 32'h0007_0000;
  localparam logic [31:0] MSK_FCTL  = 32'h001F_0000;
  localparam logic [31:0] MSK_BAUD  = 32'h03FF_0000;

  // Reset values
  localparam logic [31:0] RST_LCTL  = 32'h4000_0000;
  localparam logic [31:0] RST_BAUD  = 32'h03FF_0000;
  localparam logic [31:0] VAL_LSTAT = 32'h0000_0000;

  // Bit positions
  localparam int B_RXFLAG = 16;
  localparam int B_TXFLAG = 17;
  localparam int B_ERRFLAG = 18;
  localparam int B_DMAREQ = 19;
  localparam int B_FL_EN = 16;
  localparam int B_FL_RX = 17;
  localparam int B_FL_TX = 18;

  typedef enum logic [3:0] {
    RG_LCTL, RG_LSTAT, RG_IEN, RG_ISTAT, RG_FCTL, RG_BAUD, RG_TXF, RG_RXF, RG_NONE
  } reg_sel_e;

  // Expand byte enables into a bit mask; enable 3 covers bits 31:24
  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // Byte-lane merge followed by the word's write mask
  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  be,
                                              input logic [31:0] wmask);
    logic [31:0] m;
    m = lane_mask(be);
    return wmask & ((old_w & ~m) | (new_w & m));
  endfunction

  function automatic logic any_pending(input logic [31:0] stat,
                                       input logic [31:0] ien);
    return |(stat[B_ERRFLAG:B_RXFLAG] & ien[B_ERRFLAG:B_RXFLAG]);
  endfunction

  function automatic reg_sel_e decode_offset(input logic [7:0] ofs);
    case (ofs)
      OFS_LCTL:  return RG_LCTL;
      OFS_LSTAT: return RG_LSTAT;
      OFS_IEN:   return RG_IEN;
      OFS_ISTAT: return RG_ISTAT;
      OFS_FCTL:  return RG_FCTL;
      OFS_BAUD:  return RG_BAUD;
      OFS_TXF:   return RG_TXF;
      OFS_RXF:   return RG_RXF;
      default:   return RG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sio_rf_fifo.sv
module sio_rf_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic                           pop,
  input  logic [WIDTH-1:0]               din,
  output logic [WIDTH-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (count != FULL_CNT);
  assign do_pop  = pop  && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/sio_rf_decode.sv
module sio_rf_decode
  import sio_rf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic [7:0] ofs;

  generate
    if (ADDR_W > 8) begin : g_wide
      // Upper address bits must be zero for a hit
      always_comb begin
        ofs = addr[7:0];
        sel = (addr[ADDR_W-1:8] != '0) ? RG_NONE : decode_offset(ofs);
      end
    end else begin : g_narrow
      always_comb begin
        ofs = 8'(addr);
        sel = decode_offset(ofs);
      end
    end
  endgenerate

endmodule

// File: rtl/sio_rf_regbank.sv
module sio_rf_regbank
  import sio_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  reg_sel_e    sel,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        rx_nonempty,
  input  logic        tx_empty,
  output logic [31:0] lctl_q,
  output logic [31:0] ien_q,
  output logic [31:0] stat_q,
  output logic [31:0] fctl_q,
  output logic [31:0] baud_q,
  output logic        flush_rx,
  output logic        flush_tx,
  output logic        irq,
  output logic        dma_err
);
  logic [31:0] fctl_n, stat_n;
  logic        wr_fctl, wr_stat;

  assign wr_fctl = wr_en && (sel == RG_FCTL);
  assign wr_stat = wr_en && (sel == RG_ISTAT);

  always_comb begin
    fctl_n   = wr_fctl ? merge_bytes(fctl_q, wdata, be, MSK_FCTL) : fctl_q;
    flush_rx = wr_fctl && fctl_n[B_FL_EN] && fctl_n[B_FL_RX];
    flush_tx = wr_fctl && fctl_n[B_FL_EN] && fctl_n[B_FL_TX];
  end

  // Software write first, then the sticky sets from FIFO occupancy
  always_comb begin
    stat_n = wr_stat ? merge_bytes(stat_q, wdata, be, MSK_ISTAT) : stat_q;
    if (rx_nonempty) stat_n[B_RXFLAG] = 1'b1;
    if (tx_empty)    stat_n[B_TXFLAG] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lctl_q <= RST_LCTL;
      ien_q  <= '0;
      stat_q <= '0;
      fctl_q <= '0;
      baud_q <= RST_BAUD;
    end else begin
      if (wr_en && sel == RG_LCTL) lctl_q <= merge_bytes(lctl_q, wdata, be, MSK_LCTL);
      if (wr_en && sel == RG_IEN)  ien_q  <= merge_bytes(ien_q, wdata, be, MSK_IEN);
      if (wr_en && sel == RG_BAUD) baud_q <= merge_bytes(baud_q, wdata, be, MSK_BAUD);
      fctl_q <= fctl_n;
      stat_q <= stat_n;
    end
  end

  assign irq     = any_pending(stat_q, ien_q);
  assign dma_err = ien_q[B_DMAREQ];

endmodule

// File: rtl/sio_regfront.sv
module sio_regfront
  import sio_rf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq,
  output logic              dma_err
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  reg_sel_e     sel;
  logic         wr_en, rd_en;
  logic [31:0]  lctl_q, ien_q, stat_q, fctl_q, baud_q;
  logic [31:0]  rd_word, rdata_q;
  logic [7:0]   rx_head;
  logic [CW-1:0] tx_count, rx_count;
  logic         tx_empty, rx_empty, rx_full;

  // Named internal events, observed by the bound checker
  logic tx_push_evt, tx_pop_evt, rx_push_evt, rx_pop_evt;
  logic flush_rx_evt, flush_tx_evt;

  sio_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_en = bus_req &&  bus_we;
  assign rd_en = bus_req && !bus_we;

  sio_rf_regbank u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .sel         (sel),
    .be          (bus_be),
    .wdata       (bus_wdata),
    .rx_nonempty (!rx_empty),
    .tx_empty    (tx_empty),
    .lctl_q      (lctl_q),
    .ien_q       (ien_q),
    .stat_q      (stat_q),
    .fctl_q      (fctl_q),
    .baud_q      (baud_q),
    .flush_rx    (flush_rx_evt),
    .flush_tx    (flush_tx_evt),
    .irq         (irq),
    .dma_err     (dma_err)
  );

  assign tx_empty = (tx_count == '0);
  assign rx_empty = (rx_count == '0);
  assign rx_full  = (rx_count == FULL_CNT);

  assign tx_push_evt = wr_en && (sel == RG_TXF) && bus_be[3];
  assign tx_pop_evt  = tx_valid && tx_ready;
  assign rx_push_evt = rx_valid && rx_ready;
  assign rx_pop_evt  = rd_en && (sel == RG_RXF) && bus_be[3];

  sio_rf_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txf (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_tx_evt),
    .push  (tx_push_evt),
    .pop   (tx_pop_evt),
    .din   (bus_wdata[31:24]),
    .head  (tx_data),
    .count (tx_count)
  );

  sio_rf_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxf (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_rx_evt),
    .push  (rx_push_evt),
    .pop   (rx_pop_evt),
    .din   (rx_data),
    .head  (rx_head),
    .count (rx_count)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  always_comb begin
    case (sel)
      RG_LCTL:  rd_word = lctl_q;
      RG_LSTAT: rd_word = VAL_LSTAT;
      RG_IEN:   rd_word = ien_q;
      RG_ISTAT: rd_word = stat_q;
      RG_FCTL:  rd_word = fctl_q;
      RG_BAUD:  rd_word = baud_q;
      RG_RXF:   rd_word = rx_empty ? 32'h0 : {rx_head, 24'h0};
      default:  rd_word = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word & lane_mask(bus_be);
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/sio_regfront_chk.sv
module sio_regfront_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       irq,
  input logic                       dma_err,
  input logic [31:0]                ien_q,
  input logic [31:0]                stat_q,
  input logic [$clog2(DEPTH+1)-1:0] tx_count,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic                       tx_valid,
  input logic                       rx_valid,
  input logic                       rx_ready,
  input logic                       flush_rx_evt,
  input logic                       flush_tx_evt
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= FULL_CNT) && (rx_count <= FULL_CNT)); // R3
  AST_TX_VALID_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_count != '0)); // R3
  AST_RX_REFUSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |-> (rx_count == FULL_CNT)); // R4
  AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != '0) |=> stat_q[16]); // R5
  AST_TX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |=> stat_q[17]); // R5
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q[18:16] != 3'b000)); // R6
  AST_FLUSH_RX: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rx_evt |=> (rx_count == '0)); // R7
  AST_FLUSH_TX: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tx_evt |=> (tx_count == '0)); // R7
  AST_DMA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_err) |-> ien_q[19]); // R8

endmodule

bind sio_regfront sio_regfront_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq          (irq),
  .dma_err      (dma_err),
  .ien_q        (ien_q),
  .stat_q       (stat_q),
  .tx_count     (tx_count),
  .rx_count     (rx_count),
  .tx_valid     (tx_valid),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .flush_rx_evt (flush_rx_evt),
  .flush_tx_evt (flush_tx_evt)
);

// File: tb/sio_regfront_tb.sv
module sio_regfront_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready, irq, dma_err;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;
  logic rd_prev = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  txq[$];

  always #10 clk = ~clk;

  sio_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .irq(irq), .dma_err(dma_err)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: read data due one edge after the request; tx bytes at handshake
  always @(posedge clk) rd_prev <= bus_req && !bus_we;

  always @(negedge clk) begin
    if (rd_prev) begin
      if (exp_q.size() == 0) chk(bus_rdata, 32'hx, "R10 unexpected read");
      else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
    if (tx_valid && tx_ready) begin
      if (txq.size() == 0) chk({24'h0, tx_data}, 32'hx, "R3 unexpected tx byte");
      else chk({24'h0, tx_data}, {24'h0, txq.pop_front()}, "R3 tx order");
    end
  end

  task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = b; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] b,
                    input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = b;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic exp_rdy, input string tag);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = b;
    chk({31'h0, rx_ready}, {31'h0, exp_rdy}, tag);
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    chk({31'h0, tx_valid}, 32'h0, "R1 tx_valid");
    chk({31'h0, rx_ready}, 32'h1, "R1 rx_ready");
    chk({31'h0, irq}, 32'h0, "R1 irq");
    rd(8'h00, 4'hF, 32'h4000_0000, "R1 line control");
    rd(8'h14, 4'hF, 32'h03FF_0000, "R1 baud");
    rd(8'h08, 4'hF, 32'h0, "R1 enable");
    rd(8'h10, 4'hF, 32'h0, "R1 fifo control");
    rd(8'h04, 4'hF, 32'h0, "R1 line status");
    rd(8'h0C, 4'hF, 32'h0002_0000, "R5 tx flag after reset");

    // R2 masks and lanes
    wr(8'h00, 4'hF, 32'hFFFF_FFFF);
    rd(8'h00, 4'hF, 32'hE17F_0000, "R2 line control mask");
    wr(8'h00, 4'b1000, 32'h0);
    rd(8'h00, 4'hF, 32'h007F_0000, "R2 single lane");
    wr(8'h04, 4'hF, 32'hFFFF_FFFF);
    rd(8'h04, 4'hF, 32'h0, "R2 line status read-only");
    wr(8'h14, 4'b0100, 32'h00AA_0000);
    rd(8'h14, 4'hF, 32'h03AA_0000, "R2 baud lane");
    rd(8'h14, 4'b0100, 32'h00AA_0000, "R10 lane-masked read");

    // R9 unmapped
    wr(8'h18, 4'hF, 32'hFFFF_FFFF);
    wr(8'h01, 4'hF, 32'hFFFF_FFFF);
    rd(8'h18, 4'hF, 32'h0, "R9 unmapped read");
    rd(8'h01, 4'hF, 32'h0, "R9 misaligned read");
    rd(8'h00, 4'hF, 32'h007F_0000, "R9 no side effect");

    // R3 transmit pushes
    wr(8'h20, 4'b0111, 32'h1122_3344);
    chk({31'h0, tx_valid}, 32'h0, "R3 low lanes ignored");
    wr(8'h20, 4'b1000, 32'hA500_0000);
    txq.push_back(8'hA5);
    chk({31'h0, tx_valid}, 32'h1, "R3 push on top lane");
    chk({24'h0, tx_data}, 32'hA5, "R3 head byte");
    wr(8'h0C, 4'hF, 32'h0);
    rd(8'h0C, 4'hF, 32'h0, "R5 flag cleared by write");
    for (int i = 1; i < 16; i++) begin
      wr(8'h20, 4'hF, {8'(i), 24'h0});
      txq.push_back(8'(i));
    end
    wr(8'h20, 4'b1000, 32'hEE00_0000);  // dropped: full
    @(posedge clk); #1 tx_ready = 1'b1;
    for (int i = 0; i < 40 && tx_valid; i++) @(posedge clk);
    #1 tx_ready = 1'b0;
    chk(32'(txq.size()), 32'h0, "R3 all bytes sent, overflow dropped");
    chk({31'h0, tx_valid}, 32'h0, "R3 drained");
    rd(8'h0C, 4'hF, 32'h0002_0000, "R5 tx flag re-set");

    // R6 / R8
    wr(8'h08, 4'hF, 32'h0002_0000);
    chk({31'h0, irq}, 32'h1, "R6 tx interrupt");
    wr(8'h08, 4'hF, 32'hFFFF_FFFF);
    chk({31'h0, dma_err}, 32'h1, "R8 dma flag");
    rd(8'h08, 4'hF, 32'h000F_0000, "R2 enable mask");
    wr(8'h08, 4'hF, 32'h0008_0000);
    chk({31'h0, irq}, 32'h0, "R6 irq off without enable");
    wr(8'h08, 4'hF, 32'h0);
    chk({31'h0, dma_err}, 32'h0, "R8 dma flag clear");

    // R4 receive
    for (int i = 0; i < 16; i++) rx_send(8'h30 + 8'(i), 1'b1, "R4 rx accepted");
    rx_send(8'h99, 1'b0, "R4 rx refused when full");
    rd(8'h0C, 4'hF, 32'h0003_0000, "R5 rx flag");
    wr(8'h08, 4'hF, 32'h0001_0000);
    chk({31'h0, irq}, 32'h1, "R6 rx interrupt");
    wr(8'h0C, 4'hF, 32'h0);
    chk({31'h0, irq}, 32'h1, "R5 flag held by non-empty fifo");
    rd(8'h30, 4'b0100, 32'h0, "R4 no pop without top lane");
    rd(8'h30, 4'hF, 32'h3000_0000, "R4 first pop");
    for (int i = 1; i < 16; i++)
      rd(8'h30, 4'b1000, {8'h30 + 8'(i), 24'h0}, "R4 pop order");
    rd(8'h30, 4'hF, 32'h0, "R4 empty reads zero");
    rd(8'h20, 4'hF, 32'h0, "R4 tx address reads zero");
    wr(8'h0C, 4'hF, 32'h0);
    chk({31'h0, irq}, 32'h0, "R6 irq drops after clear");
    rd(8'h0C, 4'hF, 32'h0002_0000, "R5 rx clear, tx re-set");

    // R7 flush
    rx_send(8'h51, 1'b1, "R7 fill");
    rx_send(8'h52, 1'b1, "R7 fill");
    rx_send(8'h53, 1'b1, "R7 fill");
    wr(8'h10, 4'hF, 32'h0002_0000);
    rd(8'h30, 4'hF, 32'h5100_0000, "R7 no flush without enable");
    wr(8'h10, 4'hF, 32'h0003_0000);
    rd(8'h30, 4'hF, 32'h0, "R7 rx flushed");
    rd(8'h10, 4'hF, 32'h0003_0000, "R7 control readback");
    wr(8'h20, 4'b1000, 32'h6100_0000);
    wr(8'h20, 4'b1000, 32'h6200_0000);
    chk({31'h0, tx_valid}, 32'h1, "R7 tx loaded");
    wr(8'h10, 4'hF, 32'h0005_0000);
    chk({31'h0, tx_valid}, 32'h0, "R7 tx flushed");
    wr(8'h10, 4'hF, 32'hFFFF_FFFF);
    rd(8'h10, 4'hF, 32'h001F_0000, "R2 fifo control mask");

    repeat (3) @(posedge clk);
    chk(32'(exp_q.size()), 32'h0, "R10 all reads returned");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule